// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block reads a stream of 32-bit command words and sorts each one into a header or a data word. A header carries a 4-bit opcode in bits [31:28] and a set of fields. The block decodes those fields and works out how many data words follow the header. That count can come from the popcount of a mask field, from a 16-bit count, from a fixed number, or from a payload register that an earlier command loaded.

Data words become register-write requests. Each request carries the current class, a register offset and the data. Gather headers and their address words are combined into one descriptor. Lock acquire and release commands become lock events. Stream-id, application-id and restart commands each produce their own pulse. Unknown opcodes and unknown extend sub-opcodes are flagged. Every output is registered and appears in the cycle after the word that caused it is accepted. The block is always ready, so one word can be accepted per cycle.

The controller has three states:
- **HEADER**: the next word is decoded as a header.
- **WRITE**: data words become register writes.
- **GATHER**: words are collected as gather address words.

It has four transitions:
- **HEADER→WRITE**: a write-type header with a non-zero data count.
- **HEADER→GATHER**: a gather header.
- **WRITE→HEADER**: the last data word.
- **GATHER→HEADER**: the last address word.

A header whose data count is zero leaves the controller in HEADER.

Top module: `cmd_stream_parser`

## Requirements
- R1: After reset the controller is in HEADER, every pulse output is low and in_ready is high. The payload register holds "invalid", so an INCR_W issued before any SETPYLD raises payload_invalid.
- R2: SETCLASS (opcode 0x0) loads the class from bits [15:6], and every later write carries that class. Its 6-bit mask in [5:0] sets the number of data words, which equals the mask's popcount. Data word k goes to offset [27:16] plus the bit index of the k-th set mask bit, taken in ascending order.
- R3: INCR (0x1) takes its word count from [15:0] and its start offset from [27:16]. The offset rises by one per data word. A count of zero produces no data words.
- R4: NONINCR (0x2) works like INCR, but every data word goes to the same offset.
- R5: MASK (0x3) takes a 16-bit mask from [15:0] and an offset from [27:16]. It has popcount(mask) data words, which go to offset plus each set bit index in ascending order.
- R6: IMM (0x4) issues one write at once, with no data words. The write goes to offset [27:16], and its data is [15:0] zero-extended to 32 bits.
- R7: GATHER (0x6) takes one address word and emits a descriptor with offset [27:16], insert flag bit 15, type bit 14 and count [13:0]. GATHER_W (0xC) takes two address words, the low half first, and emits a wide descriptor with count [13:0]. In both cases the descriptor appears after the last address word.
- R8: SETPYLD (0x9) loads [15:0] into the payload register. INCR_W (0xA) and NONINCR_W (0xB) take a 22-bit offset from [21:0] and then consume as many data words as the payload register holds. A payload of zero means no data words.
- R9: INCR_W or NONINCR_W issued while the payload register is still invalid raises payload_invalid and consumes no data words.
- R10: EXTEND (0xE) reads a sub-opcode from [27:24]. Sub-opcode 0 is a lock acquire and 1 is a lock release, each with a lock index from [7:0]. Any other sub-opcode raises unknown_ext.
- R11: RESTART (0x5) emits restart_addr equal to the header shifted left by 4. SETSTRMID (0x7) emits [21:0] and SETAPPID (0x8) emits [7:0]. None of these consume data words.
- R12: Opcodes 0xD and 0xF raise unknown_op, count as headers with no data words, and leave the controller in HEADER.
- R13: Outputs appear exactly one cycle after the word is accepted. Each pulse lasts one cycle, and each accepted word causes at most one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block can accept a word (always high) |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register-write request pulse |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 22 | Register offset of the write |
| wr_data | output | 32 | Write data |
| gather_valid | output | 1 | Gather descriptor pulse |
| gather_wide | output | 1 | Descriptor came from GATHER_W |
| gather_offset | output | 12 | Gather register offset (zero when wide) |
| gather_insert | output | 1 | Insert flag (zero when wide) |
| gather_type | output | 1 | Type flag (zero when wide) |
| gather_count | output | 14 | Gather word count |
| gather_addr | output | 64 | Gather address (upper half zero when narrow) |
| lock_valid | output | 1 | Lock event pulse |
| lock_acquire | output | 1 | 1 = acquire, 0 = release |
| lock_index | output | 8 | Lock index |
| restart_valid | output | 1 | Restart pulse |
| restart_addr | output | 32 | Restart target address |
| strmid_valid | output | 1 | Stream-id pulse |
| strmid_value | output | 22 | Stream-id value |
| appid_valid | output | 1 | Application-id pulse |
| appid_value | output | 8 | Application-id value |
| unknown_op | output | 1 | Unknown opcode pulse |
| unknown_ext | output | 1 | Unknown extend sub-opcode pulse |
| payload_invalid | output | 1 | Wide write issued with invalid payload |

## Verification
The field positions are fixed by the command format, so the top has no parameters. The bench builds it as it stands, with the mask walker at 16 bits. The bench can therefore drive the widest MASK cases, up to sixteen data words each with its own offset, and the full 22-bit offsets of the wide writes. Random payload values of 0 to 4 mix zero-count wide writes with non-zero ones, and the bench tests the invalid-payload path directly after reset, before any SETPYLD.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int REGOFF_W  = 12;
    localparam int WOFF_W    = 22;
    localparam int CLASS_W   = 10;
    localparam int GCNT_W    = 14;
    localparam int IDX_W     = 8;
    localparam int GADDR_W   = 2 * WORD_W;

    typedef enum logic [3:0] {
        OP_SETCLASS  = 4'h0,
        OP_INCR      = 4'h1,
        OP_NONINCR   = 4'h2,
        OP_MASK      = 4'h3,
        OP_IMM       = 4'h4,
        OP_RESTART   = 4'h5,
        OP_GATHER    = 4'h6,
        OP_SETSTRMID = 4'h7,
        OP_SETAPPID  = 4'h8,
        OP_SETPYLD   = 4'h9,
        OP_INCR_W    = 4'hA,
        OP_NONINCR_W = 4'hB,
        OP_GATHER_W  = 4'hC,
        OP_RESTART_W = 4'hD,
        OP_EXTEND    = 4'hE,
        OP_RSVD      = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ST_HEADER = 2'd0,
        ST_WRITE  = 2'd1,
        ST_GATHER = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        WM_INCR  = 2'd0,
        WM_FIXED = 2'd1,
        WM_MASK  = 2'd2
    } wmode_e;

    function automatic logic [CNT_W-1:0] bit_total(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < CNT_W; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/cmdp_lowbit.sv
module cmdp_lowbit #(
    parameter int WIDTH = 16,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IW-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              pyld_known,
    input  logic [CNT_W-1:0]  pyld_val,
    output opcode_e           op,
    output logic [CNT_W-1:0]  follow,
    output wmode_e            wmode,
    output logic [WOFF_W-1:0] base,
    output logic [CNT_W-1:0]  wmask
);
    logic [WOFF_W-1:0] narrow_off;
    assign narrow_off = WOFF_W'(word[27:16]);

    always_comb begin
        op     = opcode_e'(word[31:28]);
        follow = '0;
        wmode  = WM_INCR;
        base   = narrow_off;
        wmask  = '0;
        case (op)
            OP_SETCLASS: begin
                wmask  = CNT_W'(word[5:0]);
                follow = bit_total(CNT_W'(word[5:0]));
                wmode  = WM_MASK;
            end
            OP_INCR: begin
                follow = word[15:0];
            end
            OP_NONINCR: begin
                follow = word[15:0];
                wmode  = WM_FIXED;
            end
            OP_MASK: begin
                wmask  = word[15:0];
                follow = bit_total(word[15:0]);
                wmode  = WM_MASK;
            end
            OP_GATHER:   follow = CNT_W'(1);
            OP_GATHER_W: follow = CNT_W'(2);
            OP_INCR_W, OP_NONINCR_W: begin
                base   = word[21:0];
                follow = pyld_known ? pyld_val : '0;
                wmode  = (op == OP_INCR_W) ? WM_INCR : WM_FIXED;
            end
            default: follow = '0;
        endcase
    end
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
    import cmdp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_word,
    output logic                 wr_valid,
    output logic [CLASS_W-1:0]   wr_class,
    output logic [WOFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]    wr_data,
    output logic                 gather_valid,
    output logic                 gather_wide,
    output logic [REGOFF_W-1:0]  gather_offset,
    output logic                 gather_insert,
    output logic                 gather_type,
    output logic [GCNT_W-1:0]    gather_count,
    output logic [GADDR_W-1:0]   gather_addr,
    output logic                 lock_valid,
    output logic                 lock_acquire,
    output logic [IDX_W-1:0]     lock_index,
    output logic                 restart_valid,
    output logic [WORD_W-1:0]    restart_addr,
    output logic                 strmid_valid,
    output logic [WOFF_W-1:0]    strmid_value,
    output logic                 appid_valid,
    output logic [IDX_W-1:0]     appid_value,
    output logic                 unknown_op,
    output logic                 unknown_ext,
    output logic                 payload_invalid
);
    localparam int MIW = $clog2(CNT_W);

    state_e               state_q, state_d;
    logic [CNT_W-1:0]     rem_q;
    wmode_e               mode_q;
    logic [WOFF_W-1:0]    base_q, cur_q;
    logic [CNT_W-1:0]     mask_q;
    logic [CLASS_W-1:0]   class_q;
    logic                 pk_q;
    logic [CNT_W-1:0]     pv_q;
    logic                 gw_q;
    logic [REGOFF_W-1:0]  goff_q;
    logic                 gins_q, gtyp_q;
    logic [GCNT_W-1:0]    gcnt_q;
    logic [WORD_W-1:0]    glo_q;

    opcode_e              dec_op;
    logic [CNT_W-1:0]     dec_follow;
    wmode_e               dec_mode;
    logic [WOFF_W-1:0]    dec_base;
    logic [CNT_W-1:0]     dec_mask;
    logic [MIW-1:0]       low_idx;
    logic [WOFF_W-1:0]    wr_off_d;
    logic                 accept;
    logic                 last_word;

    assign in_ready  = 1'b1;
    assign accept    = in_valid;
    assign last_word = (rem_q == CNT_W'(1));

    cmdp_hdr_decode u_dec (
        .word       (in_word),
        .pyld_known (pk_q),
        .pyld_val   (pv_q),
        .op         (dec_op),
        .follow     (dec_follow),
        .wmode      (dec_mode),
        .base       (dec_base),
        .wmask      (dec_mask)
    );

    cmdp_lowbit #(.WIDTH(CNT_W)) u_low (
        .vec (mask_q),
        .idx (low_idx)
    );

    always_comb begin
        wr_off_d = (mode_q == WM_MASK) ? base_q + WOFF_W'(low_idx) : cur_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEADER: begin
                if (accept && dec_follow != '0) begin
                    state_d = (dec_op == OP_GATHER || dec_op == OP_GATHER_W)
                              ? ST_GATHER : ST_WRITE;
                end
            end
            ST_WRITE, ST_GATHER: begin
                if (accept && last_word) state_d = ST_HEADER;
            end
            default: state_d = ST_HEADER;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HEADER;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;  mode_q <= WM_INCR;  base_q <= '0;  cur_q <= '0;
            mask_q <= '0; class_q <= '0; pk_q <= 1'b0; pv_q <= '0;
            gw_q <= 1'b0; goff_q <= '0; gins_q <= 1'b0; gtyp_q <= 1'b0;
            gcnt_q <= '0; glo_q <= '0;
            wr_valid <= 1'b0; wr_class <= '0; wr_offset <= '0; wr_data <= '0;
            gather_valid <= 1'b0; gather_wide <= 1'b0; gather_offset <= '0;
            gather_insert <= 1'b0; gather_type <= 1'b0; gather_count <= '0;
            gather_addr <= '0;
            lock_valid <= 1'b0; lock_acquire <= 1'b0; lock_index <= '0;
            restart_valid <= 1'b0; restart_addr <= '0;
            strmid_valid <= 1'b0; strmid_value <= '0;
            appid_valid <= 1'b0; appid_value <= '0;
            unknown_op <= 1'b0; unknown_ext <= 1'b0; payload_invalid <= 1'b0;
        end else begin
            wr_valid <= 1'b0; gather_valid <= 1'b0; lock_valid <= 1'b0;
            restart_valid <= 1'b0; strmid_valid <= 1'b0; appid_valid <= 1'b0;
            unknown_op <= 1'b0; unknown_ext <= 1'b0; payload_invalid <= 1'b0;
            if (accept) begin
                unique case (state_q)
                    ST_HEADER: begin
                        rem_q  <= dec_follow;
                        mode_q <= dec_mode;
                        base_q <= dec_base;
                        cur_q  <= dec_base;
                        mask_q <= dec_mask;
                        case (dec_op)
                            OP_SETCLASS: class_q <= in_word[15:6];
                            OP_IMM: begin
                                wr_valid  <= 1'b1;
                                wr_class  <= class_q;
                                wr_offset <= dec_base;
                                wr_data   <= WORD_W'(in_word[15:0]);
                            end
                            OP_RESTART: begin
                                restart_valid <= 1'b1;
                                restart_addr  <= {in_word[27:0], 4'b0000};
                            end
                            OP_GATHER: begin
                                gw_q   <= 1'b0;
                                goff_q <= in_word[27:16];
                                gins_q <= in_word[15];
                                gtyp_q <= in_word[14];
                                gcnt_q <= in_word[13:0];
                            end
                            OP_GATHER_W: begin
                                gw_q   <= 1'b1;
                                goff_q <= '0;
                                gins_q <= 1'b0;
                                gtyp_q <= 1'b0;
                                gcnt_q <= in_word[13:0];
                            end
                            OP_SETSTRMID: begin
                                strmid_valid <= 1'b1;
                                strmid_value <= in_word[21:0];
                            end
                            OP_SETAPPID: begin
                                appid_valid <= 1'b1;
                                appid_value <= in_word[7:0];
                            end
                            OP_SETPYLD: begin
                                pk_q <= 1'b1;
                                pv_q <= in_word[15:0];
                            end
                            OP_INCR_W, OP_NONINCR_W: begin
                                if (!pk_q) payload_invalid <= 1'b1;
                            end
                            OP_EXTEND: begin
                                if (in_word[27:25] == 3'b000) begin
                                    lock_valid   <= 1'b1;
                                    lock_acquire <= ~in_word[24];
                                    lock_index   <= in_word[7:0];
                                end else begin
                                    unknown_ext <= 1'b1;
                                end
                            end
                            OP_RESTART_W, OP_RSVD: unknown_op <= 1'b1;
                            default: ;
                        endcase
                    end
                    ST_WRITE: begin
                        wr_valid  <= 1'b1;
                        wr_class  <= class_q;
                        wr_offset <= wr_off_d;
                        wr_data   <= in_word;
                        rem_q     <= rem_q - CNT_W'(1);
                        if (mode_q == WM_INCR) cur_q <= cur_q + WOFF_W'(1);
                        if (mode_q == WM_MASK) mask_q <= mask_q & (mask_q - CNT_W'(1));
                    end
                    ST_GATHER: begin
                        rem_q <= rem_q - CNT_W'(1);
                        if (gw_q && rem_q == CNT_W'(2)) begin
                            glo_q <= in_word;
                        end else begin
                            gather_valid  <= 1'b1;
                            gather_wide   <= gw_q;
                            gather_offset <= goff_q;
                            gather_insert <= gins_q;
                            gather_type   <= gtyp_q;
                            gather_count  <= gcnt_q;
                            gather_addr   <= gw_q ? {in_word, glo_q}
                                                  : {{WORD_W{1'b0}}, in_word};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_stream_parser_chk.sv
module cmd_stream_parser_chk
    import cmdp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [WORD_W-1:0]  in_word,
    input state_e             state,
    input logic               wr_valid,
    input logic [WORD_W-1:0]  wr_data,
    input logic               gather_valid,
    input logic               lock_valid,
    input logic [IDX_W-1:0]   lock_index,
    input logic               restart_valid,
    input logic [WORD_W-1:0]  restart_addr,
    input logic               strmid_valid,
    input logic               appid_valid,
    input logic               unknown_op,
    input logic               unknown_ext,
    input logic               payload_invalid
);
    logic [8:0] ev;
    assign ev = {wr_valid, gather_valid, lock_valid, restart_valid, strmid_valid,
                 appid_valid, unknown_op, unknown_ext, payload_invalid};

    p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

    p_one_event_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ev == '0);

    p_write_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && state == ST_WRITE) |-> wr_valid && wr_data == $past(in_word));

    p_imm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && state == ST_HEADER && in_word[31:28] == 4'h4)
        |-> wr_valid && wr_data == {16'h0000, $past(in_word[15:0])});

    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_valid |-> lock_index == $past(in_word[7:0]) && $past(in_word[31:28]) == 4'hE);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> restart_addr == {$past(in_word[27:0]), 4'b0000});

    p_unknown_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && state == ST_HEADER && in_word[31:28] == 4'hF)
        |-> unknown_op && state == ST_HEADER);
endmodule

bind cmd_stream_parser cmd_stream_parser_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_word         (in_word),
    .state           (state_q),
    .wr_valid        (wr_valid),
    .wr_data         (wr_data),
    .gather_valid    (gather_valid),
    .lock_valid      (lock_valid),
    .lock_index      (lock_index),
    .restart_valid   (restart_valid),
    .restart_addr    (restart_addr),
    .strmid_valid    (strmid_valid),
    .appid_valid     (appid_valid),
    .unknown_op      (unknown_op),
    .unknown_ext     (unknown_ext),
    .payload_invalid (payload_invalid)
);

// File: tb/cmd_stream_parser_bench.sv
module cmd_stream_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [9:0]  wr_class;
    logic [21:0] wr_offset;
    logic [31:0] wr_data;
    logic        gather_valid, gather_wide, gather_insert, gather_type;
    logic [11:0] gather_offset;
    logic [13:0] gather_count;
    logic [63:0] gather_addr;
    logic        lock_valid, lock_acquire;
    logic [7:0]  lock_index;
    logic        restart_valid;
    logic [31:0] restart_addr;
    logic        strmid_valid;
    logic [21:0] strmid_value;
    logic        appid_valid;
    logic [7:0]  appid_value;
    logic        unknown_op, unknown_ext, payload_invalid;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    cmd_stream_parser u_cmd_stream_parser (.*);

    // reference model state
    int          m_st = 0;      // 0 header, 1 write, 2 gather
    int          m_rem = 0;
    int          m_mode = 0;    // 0 incr, 1 fixed, 2 mask
    int          m_cur = 0;
    int          m_base = 0;
    logic [15:0] m_mask = '0;
    logic [9:0]  m_cls = '0;
    bit          m_pk = 0;
    int          m_pv = 0;
    bit          m_gw = 0;
    logic [31:0] m_glo = '0;
    logic [11:0] m_goff = '0;
    bit          m_gins = 0, m_gtyp = 0;
    logic [13:0] m_gcnt = '0;
    string       m_tag = "R3";

    // expected results for the current word
    logic [64:0] e_wr;
    logic [93:0] e_ga;
    logic [9:0]  e_lk;
    logic [67:0] e_mi;
    string       e_wtag, e_mtag;

    function automatic int ones(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] w);
        e_wr = '0; e_ga = '0; e_lk = '0; e_mi = '0;
        e_wtag = m_tag; e_mtag = "R11";
        if (m_st == 1) begin
            int off;
            if (m_mode == 2) begin
                int b = 0;
                for (int i = 15; i >= 0; i--) if (m_mask[i]) b = i;
                off = m_base + b;
                m_mask[b] = 1'b0;
            end else begin
                off = m_cur;
                if (m_mode == 0) m_cur++;
            end
            e_wr = {1'b1, m_cls, off[21:0], w};
            m_rem--;
            if (m_rem == 0) m_st = 0;
        end else if (m_st == 2) begin
            if (m_gw && m_rem == 2) m_glo = w;
            else e_ga = {1'b1, m_gw, m_goff, m_gins, m_gtyp, m_gcnt,
                         m_gw ? {w, m_glo} : {32'h0, w}};
            m_rem--;
            if (m_rem == 0) m_st = 0;
        end else begin
            case (w[31:28])
                4'h0: begin
                    m_cls = w[15:6]; m_tag = "R2"; e_wtag = "R2";
                    if (w[5:0] != 0) begin
                        m_st = 1; m_mode = 2; m_base = int'(w[27:16]);
                        m_mask = {10'h0, w[5:0]}; m_rem = ones({10'h0, w[5:0]});
                    end
                end
                4'h1, 4'h2: begin
                    m_tag = (w[31:28] == 4'h1) ? "R3" : "R4"; e_wtag = m_tag;
                    if (w[15:0] != 0) begin
                        m_st = 1; m_mode = (w[31:28] == 4'h1) ? 0 : 1;
                        m_cur = int'(w[27:16]); m_rem = int'(w[15:0]);
                    end
                end
                4'h3: begin
                    m_tag = "R5"; e_wtag = "R5";
                    if (w[15:0] != 0) begin
                        m_st = 1; m_mode = 2; m_base = int'(w[27:16]);
                        m_mask = w[15:0]; m_rem = ones(w[15:0]);
                    end
                end
                4'h4: begin
                    e_wtag = "R6";
                    e_wr = {1'b1, m_cls, 10'h0, w[27:16], 16'h0, w[15:0]};
                end
                4'h5: e_mi[67:35] = {1'b1, w[27:0], 4'h0};
                4'h6: begin
                    m_st = 2; m_rem = 1; m_gw = 0; m_goff = w[27:16];
                    m_gins = w[15]; m_gtyp = w[14]; m_gcnt = w[13:0];
                end
                4'h7: e_mi[34:12] = {1'b1, w[21:0]};
                4'h8: e_mi[11:3] = {1'b1, w[7:0]};
                4'h9: begin m_pk = 1; m_pv = int'(w[15:0]); end
                4'hA, 4'hB: begin
                    m_tag = "R8"; e_wtag = "R8";
                    if (!m_pk) begin e_mi[0] = 1'b1; e_mtag = "R9"; end
                    else if (m_pv != 0) begin
                        m_st = 1; m_mode = (w[31:28] == 4'hA) ? 0 : 1;
                        m_cur = int'(w[21:0]); m_rem = m_pv;
                    end
                end
                4'hC: begin
                    m_st = 2; m_rem = 2; m_gw = 1; m_goff = '0;
                    m_gins = 0; m_gtyp = 0; m_gcnt = w[13:0];
                end
                4'hE: begin
                    if (w[27:24] == 4'h0 || w[27:24] == 4'h1)
                        e_lk = {1'b1, w[27:24] == 4'h0, w[7:0]};
                    else begin e_mi[1] = 1'b1; e_mtag = "R10"; end
                end
                default: begin e_mi[2] = 1'b1; e_mtag = "R12"; end
            endcase
        end
    endtask

    task automatic compare();
        logic [64:0] a_wr;
        logic [93:0] a_ga;
        logic [9:0]  a_lk;
        logic [67:0] a_mi;
        a_wr = wr_valid ? {1'b1, wr_class, wr_offset, wr_data} : '0;
        a_ga = gather_valid ? {1'b1, gather_wide, gather_offset, gather_insert,
                               gather_type, gather_count, gather_addr} : '0;
        a_lk = lock_valid ? {1'b1, lock_acquire, lock_index} : '0;
        a_mi = {restart_valid, restart_valid ? restart_addr : 32'h0,
                strmid_valid, strmid_valid ? strmid_value : 22'h0,
                appid_valid, appid_valid ? appid_value : 8'h0,
                unknown_op, unknown_ext, payload_invalid};
        check(a_wr === e_wr, e_wtag, 128'(a_wr), 128'(e_wr));
        check(a_ga === e_ga, "R7", 128'(a_ga), 128'(e_ga));
        check(a_lk === e_lk, "R10", 128'(a_lk), 128'(e_lk));
        check(a_mi === e_mi, e_mtag, 128'(a_mi), 128'(e_mi));
    endtask

    // R13: one word per cycle, result sampled one cycle after acceptance
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        model(w);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        compare();
    endtask

    task automatic flush_data();
        while (m_st != 0) send($urandom());
    endtask

    task automatic rand_cmd();
        logic [31:0] h;
        logic [3:0]  op;
        op = 4'($urandom_range(0, 15));
        h  = {op, 28'($urandom())};
        case (op)
            4'h1, 4'h2: h[15:0] = 16'($urandom_range(0, 5));
            4'h9:       h[15:0] = 16'($urandom_range(0, 4));
            4'hE:       h[27:24] = 4'($urandom_range(0, 3));
            default: ;
        endcase
        send(h);
        flush_data();
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(in_ready === 1'b1, "R1", 128'(in_ready), 128'(1));
        check({wr_valid, gather_valid, lock_valid, restart_valid, strmid_valid,
               appid_valid, unknown_op, unknown_ext, payload_invalid} === 9'h0,
              "R1", 128'(0), 128'(0));
        // R1/R9: wide write before any SETPYLD
        send(32'hA000_0010);
        check(payload_invalid === 1'b1, "R1", 128'(payload_invalid), 128'(1));
        send(32'h1123_0000);                 // R3 zero count
        send(32'h0100_554D);                 // R2 class 0x155, mask 0x0D
        flush_data();
        send(32'h0100_556D); flush_data();   // R2 mask 0x2D
        send(32'h1020_0003); flush_data();   // R3
        send(32'h2030_0002); flush_data();   // R4
        send(32'h3040_8001); flush_data();   // R5
        send(32'h3050_FFFF); flush_data();   // R5 all sixteen bits
        send(32'h4077_BEEF);                 // R6
        send(32'h9000_0000);                 // R8 payload zero
        send(32'hA012_3456);
        send(32'h9000_0003);
        send(32'hB3AB_CDEF); flush_data();   // R8 fixed wide
        send(32'hA3FF_FFFE); flush_data();   // R8 incrementing wide
        send(32'h6ABC_C123); flush_data();   // R7
        send(32'hC000_1FFF); flush_data();   // R7 wide
        send(32'hE000_0007);                 // R10 acquire
        send(32'hE100_0042);                 // R10 release
        send(32'hE500_0001);                 // R10 unknown extend
        send(32'hF123_4567);                 // R12
        send(32'hD000_0000);                 // R12
        send(32'h1060_0001); flush_data();   // R12 header state kept
        send(32'h5123_4567);                 // R11
        send(32'h7FFF_FFFF);                 // R11
        send(32'h8000_00A5);                 // R11
        for (int i = 0; i < 600; i++) rand_cmd();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule